// File: doc/BRIEF.md
# Encoder Speed Window Counter

This block turns a stream of per-cycle encoder count pulses into a speed figure. A free-running time-base counter climbs from zero to a programmable limit, returns to zero on reaching it, and flips an internal gate level each time. Inside the block, that gate is the capture trigger. A second counter accumulates one unit for every cycle in which the pulse input is high. On every rising gate edge, it copies its running total into a result register and starts again from zero. Because only rising edges latch, one measurement covers two full time-base periods.

Software uses a small register port. It selects the mode bits, writes the period limit, and starts or halts counting through a control word. It reads the latest speed value and a flag that shows whether that value is new. The pulse input is expected from an external quadrature decoder. The block does no direction decoding and no revolution counting.

Top module: `qsm_speed`

## Requirements
- R1: Counting is active only while MODE (address 1) has bit 0 (speed enable) and bit 1 (decoder enable) both set. While inactive, the time-base counter, the gate level and the capture counter hold their values.
- R2: While active and running, the time-base counter advances by one each cycle. When its value is greater than or equal to PERIOD (address 2), it returns to zero and the gate level inverts, so each gate phase lasts PERIOD+1 cycles.
- R3: One cycle after the gate rises, the result register takes the capture count that was reached before clearing. The capture counter restarts in that same cycle, so the first window after a start holds PERIOD+1 samples and each later window holds 2*(PERIOD+1).
- R4: While active and running, the capture counter grows by one for each cycle in which cnt_pulse is high. This includes the latch cycle, whose pulse becomes the first count of the new window.
- R5: The capture counter saturates at all ones (CAP_W bits) instead of wrapping.
- R6: A write to CTRL (address 0) with bit 0 (clock enable) and bit 1 (trigger) both set starts counting. Bit 0 alone does not start counting. A CTRL write with bit 2 set and bits 1:0 not both set halts counting.
- R7: A CTRL write with bit 1 set clears the time-base counter, the capture counter and the gate level to zero in the cycle of the write.
- R8: RESULT (address 3) returns the latest speed value. STATUS (address 4) bit 0 is the valid flag, which sets on each latch and clears on a read of RESULT. If a latch and a RESULT read fall in the same cycle, the flag stays set. STATUS bit 1 is the gate level and bit 2 is the running state.
- R9: Read data is registered: rd_data changes on the edge that samples rd_en, and it holds between reads. Addresses 5 to 7 read as zero.
- R10: PERIOD and MODE read back what was last written to them. After reset, PERIOD is PER_RST and MODE, STATUS and RESULT are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Registered read data |
| cnt_pulse | input | 1 | Qualified encoder count pulse, one count per high cycle |

## Verification
A window latch and a software read of RESULT can land on the same edge. The valid flag is set by one and cleared by the other. To provoke this, the bench counts cycles from the starting CTRL write so that its RESULT read is sampled on exactly the edge that latches the first window. The test then requires STATUS to still show valid and RESULT to show the full first-window count. A software trigger issued mid-window is also judged: the gate must read back low, and the next value must again be a first-window count.

// File: rtl/qsm_pkg.sv
package qsm_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  // register addresses
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 3'd1;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd2;
  localparam logic [ADDR_W-1:0] A_RESULT = 3'd3;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd4;

  // control word bits
  localparam int C_CLKEN = 0;
  localparam int C_TRIG  = 1;
  localparam int C_HALT  = 2;

  // mode word bits
  localparam int M_SPEED = 0;
  localparam int M_QUAD  = 1;

  // status word bits
  localparam int S_VALID = 0;
  localparam int S_GATE  = 1;
  localparam int S_RUN   = 2;

  typedef struct packed {
    logic speed_en;
    logic quad_en;
  } mode_t;

endpackage

// File: rtl/qsm_regs.sv
module qsm_regs
  import qsm_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int CAP_W   = 16,
  parameter int PER_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CAP_W-1:0]  result,
  input  logic              gate,
  input  logic              latch,
  output logic              active,
  output logic              running,
  output logic              kick,
  output logic [PER_W-1:0]  period,
  output logic              valid,
  output logic [DATA_W-1:0] rd_data
);

  mode_t mode_q;
  logic  ctrl_wr;
  logic  start;
  logic  result_rd;
  logic  unused_wr_bits;

  assign ctrl_wr   = wr_en && (wr_addr == A_CTRL);
  assign start     = ctrl_wr && wr_data[C_CLKEN] && wr_data[C_TRIG];
  assign kick      = ctrl_wr && wr_data[C_TRIG];
  assign result_rd = rd_en && (rd_addr == A_RESULT);
  assign active    = mode_q.speed_en && mode_q.quad_en;
  assign unused_wr_bits = ^wr_data;

  // mode and period registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      period <= PER_W'(PER_RST);
    end else if (wr_en) begin
      if (wr_addr == A_MODE) begin
        mode_q.speed_en <= wr_data[M_SPEED];
        mode_q.quad_en  <= wr_data[M_QUAD];
      end
      if (wr_addr == A_PERIOD) begin
        period <= wr_data[PER_W-1:0];
      end
    end
  end

  // run state
  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
    end else if (ctrl_wr && wr_data[C_HALT]) begin
      running <= 1'b0;
    end
  end

  // new-result flag: a latch wins over a clearing read
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (latch) begin
      valid <= 1'b1;
    end else if (result_rd) begin
      valid <= 1'b0;
    end
  end

  // registered read port
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_MODE: begin
        rd_mux[M_SPEED] = mode_q.speed_en;
        rd_mux[M_QUAD]  = mode_q.quad_en;
      end
      A_PERIOD: rd_mux[PER_W-1:0] = period;
      A_RESULT: rd_mux[CAP_W-1:0] = result;
      A_STATUS: begin
        rd_mux[S_VALID] = valid;
        rd_mux[S_GATE]  = gate;
        rd_mux[S_RUN]   = running;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_mux;
    end
  end

endmodule

// File: rtl/qsm_timebase.sv
module qsm_timebase #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic             en,
  input  logic [PER_W-1:0] period,
  output logic [PER_W-1:0] tb_cnt,
  output logic             gate
);

  logic hit;

  // greater-or-equal so a shrinking period never forces a full wrap
  assign hit = (tb_cnt >= period);

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      tb_cnt <= '0;
      gate   <= 1'b0;
    end else if (en) begin
      if (hit) begin
        tb_cnt <= '0;
        gate   <= ~gate;
      end else begin
        tb_cnt <= tb_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/qsm_capture.sv
module qsm_capture #(
  parameter int CAP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kick,
  input  logic             en,
  input  logic             pulse,
  input  logic             gate,
  output logic             latch,
  output logic [CAP_W-1:0] cap_cnt,
  output logic [CAP_W-1:0] result
);

  localparam logic [CAP_W-1:0] CAP_MAX = {CAP_W{1'b1}};

  logic gate_d;
  logic inc;

  assign inc   = en && pulse;
  assign latch = gate && !gate_d;

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      gate_d <= 1'b0;
    end else begin
      gate_d <= gate;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || kick) begin
      cap_cnt <= '0;
    end else if (latch) begin
      cap_cnt <= CAP_W'(inc);
    end else if (inc && (cap_cnt != CAP_MAX)) begin
      cap_cnt <= cap_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (latch) begin
      result <= cap_cnt;
    end
  end

endmodule

// File: rtl/qsm_speed.sv
module qsm_speed
  import qsm_pkg::*;
#(
  parameter int PER_W   = 16,
  parameter int CAP_W   = 16,
  parameter int PER_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              cnt_pulse
);

  logic             active;
  logic             running;
  logic             kick;
  logic             valid;
  logic             gate;
  logic             latch;
  logic             run_en;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] tb_cnt;
  logic [CAP_W-1:0] cap_cnt;
  logic [CAP_W-1:0] result;

  assign run_en = active && running;

  qsm_regs #(
    .PER_W  (PER_W),
    .CAP_W  (CAP_W),
    .PER_RST(PER_RST)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .result (result),
    .gate   (gate),
    .latch  (latch),
    .active (active),
    .running(running),
    .kick   (kick),
    .period (period),
    .valid  (valid),
    .rd_data(rd_data)
  );

  qsm_timebase #(
    .PER_W(PER_W)
  ) u_tb (
    .clk   (clk),
    .rst   (rst),
    .kick  (kick),
    .en    (run_en),
    .period(period),
    .tb_cnt(tb_cnt),
    .gate  (gate)
  );

  qsm_capture #(
    .CAP_W(CAP_W)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .kick   (kick),
    .en     (run_en),
    .pulse  (cnt_pulse),
    .gate   (gate),
    .latch  (latch),
    .cap_cnt(cap_cnt),
    .result (result)
  );

endmodule

// File: rtl/qsm_speed_chk.sv
module qsm_speed_chk
  import qsm_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int CAP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              active,
  input logic              running,
  input logic              kick,
  input logic              latch,
  input logic              gate,
  input logic              valid,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [PER_W-1:0]  period,
  input logic [PER_W-1:0]  tb_cnt,
  input logic [CAP_W-1:0]  cap_cnt,
  input logic [CAP_W-1:0]  result
);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!(active && running) && !kick) |=> ($stable(gate) && $stable(tb_cnt) && $stable(cap_cnt)));

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (active && running && !kick && (tb_cnt >= period)) |=> ((tb_cnt == '0) && (gate != $past(gate))));

  p_latch_value_r3: assert property (@(posedge clk) disable iff (rst)
    (latch && !kick) |=> (result == $past(cap_cnt)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    ((cap_cnt == {CAP_W{1'b1}}) && !latch && !kick) |=> (cap_cnt == {CAP_W{1'b1}}));

  p_trigger_clear_r7: assert property (@(posedge clk) disable iff (rst)
    kick |=> ((tb_cnt == '0) && !gate && (cap_cnt == '0)));

  p_valid_set_r8: assert property (@(posedge clk) disable iff (rst)
    latch |=> valid);

  p_valid_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (rd_addr == A_RESULT) && !latch) |=> !valid);

endmodule

bind qsm_speed qsm_speed_chk #(
  .PER_W(PER_W),
  .CAP_W(CAP_W)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .active (active),
  .running(running),
  .kick   (kick),
  .latch  (latch),
  .gate   (gate),
  .valid  (valid),
  .rd_en  (rd_en),
  .rd_addr(rd_addr),
  .period (period),
  .tb_cnt (tb_cnt),
  .cap_cnt(cap_cnt),
  .result (result)
);

// File: tb/test_qsm_speed.sv
`timescale 1ns/1ps
module test_qsm_speed;

  localparam int CAP_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        cnt_pulse = 1'b0;
  int          pmode = 0;
  int          n_checks = 0;
  int          n_errors = 0;

  always #2.5 clk = ~clk;

  qsm_speed #(.PER_W(16), .CAP_W(CAP_W), .PER_RST(0)) i_qsm_speed (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .cnt_pulse(cnt_pulse)
  );

  // pulse pattern: 0 low, 1 high, 2 alternating
  always @(negedge clk) begin
    case (pmode)
      1:       cnt_pulse <= 1'b1;
      2:       cnt_pulse <= ~cnt_pulse;
      default: cnt_pulse <= 1'b0;
    endcase
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_valid(input string req);
    logic [31:0] s;
    bit seen = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      rd(3'd4, s);
      if (s[0]) begin
        seen = 1'b1;
        break;
      end
    end
    chk({req, " valid flag seen"}, 32'(seen), 32'd1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(3'd4, d); chk("R10 status after reset", d, 32'd0);
    rd(3'd3, d); chk("R10 result after reset", d, 32'd0);
    rd(3'd2, d); chk("R10 period after reset", d, 32'd0);
    rd(3'd1, d); chk("R10 mode after reset", d, 32'd0);
  endtask

  task automatic t_inactive();
    logic [31:0] d;
    pmode = 1;
    wr(3'd2, 32'd9);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'd3);
    repeat (60) @(negedge clk);
    rd(3'd4, d); chk("R1 only speed bit: running, gate low, no valid", d, 32'd4);
    rd(3'd3, d); chk("R1 result untouched", d, 32'd0);
    rd(3'd1, d); chk("R10 mode readback", d, 32'd1);
  endtask

  task automatic t_no_start();
    logic [31:0] d;
    wr(3'd0, 32'd4);
    wr(3'd1, 32'd3);
    wr(3'd0, 32'd1);
    repeat (40) @(negedge clk);
    rd(3'd4, d); chk("R6 enable bit alone does not start", d, 32'd0);
  endtask

  task automatic t_window_high();
    logic [31:0] d;
    pmode = 1;
    wr(3'd2, 32'd9);
    rd(3'd2, d); chk("R10 period readback", d, 32'd9);
    wr(3'd0, 32'd3);
    wait_valid("R3 first window");
    rd(3'd3, d); chk("R3 first window is PERIOD+1", d, 32'd10);
    rd(3'd4, d); chk("R8 read of result clears valid", 32'(d[0]), 32'd0);
    wait_valid("R2 second window");
    rd(3'd3, d); chk("R2 R4 full window is 2*(PERIOD+1)", d, 32'd20);
  endtask

  task automatic t_alternating();
    logic [31:0] d;
    pmode = 2;
    wr(3'd0, 32'd3);
    wait_valid("R4 alt first");
    rd(3'd3, d);
    wait_valid("R4 alt second");
    rd(3'd3, d); chk("R4 alternating pulses count half", d, 32'd10);
  endtask

  task automatic t_kick();
    logic [31:0] d;
    pmode = 1;
    wr(3'd0, 32'd3);
    repeat (15) @(negedge clk);
    wr(3'd0, 32'd2);
    rd(3'd4, d); chk("R7 trigger clears gate, keeps running", 32'(d[2:1]), 32'd2);
    rd(3'd3, d);
    wait_valid("R7 after trigger");
    rd(3'd3, d); chk("R7 first window after trigger", d, 32'd10);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    pmode = 1;
    wr(3'd0, 32'd4);
    rd(3'd3, d);
    rd(3'd4, d); chk("R6 halt clears running", 32'(d[2]), 32'd0);
    wr(3'd0, 32'd3);
    // the latch lands PERIOD+2 edges after the starting write edge
    repeat (10) @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd3;
    @(negedge clk);
    rd_en = 1'b0;
    rd(3'd4, d); chk("R8 latch beats same-cycle result read", 32'(d[0]), 32'd1);
    rd(3'd3, d); chk("R8 collided window value", d, 32'd10);
  endtask

  task automatic t_saturate();
    logic [31:0] d;
    pmode = 1;
    wr(3'd2, 32'd200);
    wr(3'd0, 32'd3);
    wait_valid("R5 first");
    rd(3'd3, d); chk("R5 first window below limit", d, 32'd201);
    wait_valid("R5 second");
    rd(3'd3, d); chk("R5 saturates at all ones", d, 32'd255);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(3'd7, d); chk("R9 unmapped address reads zero", d, 32'd0);
    rd(3'd5, d); chk("R9 unmapped address 5 reads zero", d, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_inactive();
    t_no_start();
    t_window_high();
    t_alternating();
    t_kick();
    t_collide();
    t_saturate();
    t_unmapped();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule